// File: doc/BRIEF.md
# Region Coded-Block Map Selector

This block decides, for every 8x8 pixel block of a frame, whether the block is coded. The decision depends on two inputs. The first is the kind of the current frame, which is latched at each start-of-frame pulse. The second is a coarse map that software loads, with one bit for each 32x32-pixel tile. The map lets an encoder refresh the area outside a region of interest less often than the area inside it. Intra frames and full inter frames code every block. Mapped inter frames code a block only when its tile bit is set.

Block coordinates arrive in scan order with a valid strobe, and the coded flag comes back one clock later. Software writes the map one word at a time into a shadow copy. The copy that the decision reads is loaded from the shadow only at a start-of-frame pulse. Writes made during a frame therefore never change the decisions of that frame.

Top module: `roi_block_gate`

## Requirements
- R1: While reset is held low, and in the first cycle after it, `coded_valid` and `coded` are 0. Reset clears both map copies to all zeros. After reset the frame kind is intra, until the first `frame_start` arrives.
- R2: `coded_valid` equals the value `blk_valid` had one clock earlier.
- R3: When `coded_valid` is 0, `coded` is 0.
- R4: A block at coordinates (`blk_x`, `blk_y`) belongs to tile (`blk_x`>>2, `blk_y`>>2), so each tile covers 4x4 blocks.
- R5: The map bit of tile (tx, ty) has index ty*TILE_COLS+tx. It is held in map word index/WORD_W, at bit index%WORD_W of that word.
- R6: In an intra frame (`frame_kind` code 0), every valid block gives `coded`=1, whatever the map holds.
- R7: In a full inter frame (code 1), every valid block gives `coded`=1.
- R8: In a mapped inter frame (code 2), `coded` equals the map bit of the block's tile, taken from the decision copy of the map.
- R9: The reserved code 3 behaves like intra: every valid block gives `coded`=1.
- R10: A map write reaches the decision copy only at the next `frame_start` that comes after the cycle of the write. A write in the same cycle as `frame_start` waits for the following `frame_start`.
- R11: A block presented in the same cycle as `frame_start` is decided with the frame kind and map that applied before that pulse. The new kind and map apply from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse: latch `frame_kind` and load the decision map from the shadow |
| frame_kind | input | 2 | Frame kind: 0 intra, 1 full inter, 2 mapped inter, 3 reserved |
| blk_valid | input | 1 | Block coordinate strobe |
| blk_x | input | BX_W (8) | Block column in 8x8 units |
| blk_y | input | BY_W (7) | Block row in 8x8 units |
| map_we | input | 1 | Shadow map word write enable |
| map_waddr | input | WA_W (6) | Shadow map word index |
| map_wdata | input | WORD_W (32) | Shadow map word data |
| coded_valid | output | 1 | Decision strobe, one cycle after `blk_valid` |
| coded | output | 1 | 1 when the block is to be coded |

## Verification
The bench uses an 8x4-tile map with 8-bit words. Every block position is swept once for each frame kind. An all-zero map is separated from a mixed map whose bit patterns differ in every word. A wrong tile shift or a swapped word or bit order therefore shows up as a different set of coded blocks. The sweeps in intra, full-inter and reserved frames are run over a map that is not all ones, so a kind that wrongly consults the map is exposed. Writes are also made in the middle of a frame, and in the same cycle as a start pulse together with a block, so that a map or kind that changes too early is told apart from one that changes at the right boundary.

// File: rtl/roi_map_pkg.sv
// Package: frame kinds shared by the coded-block selector.
// Assumes the frame kind travels as a 2-bit code on the ports.
package roi_map_pkg;
    typedef enum logic [1:0] {
        FK_INTRA     = 2'd0,
        FK_INTER_ALL = 2'd1,
        FK_INTER_ROI = 2'd2,
        FK_RESERVED  = 2'd3
    } frame_kind_e;
endpackage

// File: rtl/roi_tile_index.sv
// Module: turns 8x8 block coordinates into a flat tile-map bit index.
// Assumes TILE_COLS is a power of two, so ty*TILE_COLS+tx is a concatenation.
module roi_tile_index #(
    parameter int SUB_LOG2 = 2,
    parameter int TX_W     = 6,
    parameter int TY_W     = 5,
    localparam int BX_W    = TX_W + SUB_LOG2,
    localparam int BY_W    = TY_W + SUB_LOG2,
    localparam int IDX_W   = TX_W + TY_W
) (
    input  logic [BX_W-1:0]  blk_x,
    input  logic [BY_W-1:0]  blk_y,
    output logic [IDX_W-1:0] tile_idx
);
    // Drop the sub-tile bits of each coordinate and pack row above column.
    always_comb begin
        tile_idx = {blk_y[BY_W-1:SUB_LOG2], blk_x[BX_W-1:SUB_LOG2]};
    end
endmodule

// File: rtl/roi_map_store.sv
// Module: double copy of the tile map. Software writes words into the shadow.
// The decision copy is loaded from the shadow on a frame boundary pulse.
// Assumes WORDS*WORD_W == MAP_BITS and that WORDS is a power of two.
module roi_map_store #(
    parameter int MAP_BITS = 2048,
    parameter int WORD_W   = 32,
    parameter int IDX_W    = 11,
    localparam int WORDS   = MAP_BITS / WORD_W,
    localparam int WA_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WA_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              swap,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_bit
);
    logic [MAP_BITS-1:0] shadow_q;
    logic [MAP_BITS-1:0] active_q;

    // Shadow copy: takes software word writes at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (wr_en) begin
            shadow_q[int'(wr_addr)*WORD_W +: WORD_W] <= wr_data;
        end
    end

    // Decision copy: reloaded from the shadow only on a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (swap) begin
            active_q <= shadow_q;
        end
    end

    // Read the tile bit for the current block.
    always_comb begin
        rd_bit = active_q[rd_idx];
    end

    AST_MAP_HELD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(active_q)); // R10
endmodule

// File: rtl/roi_code_decide.sv
// Module: holds the current frame kind and registers the per-block coded flag.
// Assumes map_bit already belongs to the block presented in the same cycle.
module roi_code_decide
    import roi_map_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic [1:0] frame_kind,
    input  logic       blk_valid,
    input  logic       map_bit,
    output logic       coded_valid,
    output logic       coded
);
    frame_kind_e kind_q;
    logic        use_map;

    // Latch the frame kind at each frame boundary; intra after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= FK_INTRA;
        end else if (frame_start) begin
            kind_q <= frame_kind_e'(frame_kind);
        end
    end

    // Only the mapped inter kind consults the map.
    always_comb begin
        use_map = (kind_q == FK_INTER_ROI);
    end

    // One-cycle output register for the strobe and the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coded_valid <= 1'b0;
            coded       <= 1'b0;
        end else begin
            coded_valid <= blk_valid;
            coded       <= blk_valid && (!use_map || map_bit);
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |=> coded_valid); // R2
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_valid |=> !coded_valid); // R2
    AST_UNMAPPED_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && kind_q != FK_INTER_ROI) |=> coded); // R6
    AST_MAP_CLEAR_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && kind_q == FK_INTER_ROI && !map_bit) |=> !coded); // R8
endmodule

// File: rtl/roi_block_gate.sv
// Module: top of the region coded-block selector.
// Joins the tile index, the double-buffered map and the decision register.
// Assumes TILE_COLS, TILE_ROWS and the word count are powers of two, each at least 2.
module roi_block_gate #(
    parameter int TILE_COLS = 64,
    parameter int TILE_ROWS = 32,
    parameter int WORD_W    = 32,
    parameter int SUB_LOG2  = 2,
    localparam int TX_W     = $clog2(TILE_COLS),
    localparam int TY_W     = $clog2(TILE_ROWS),
    localparam int BX_W     = TX_W + SUB_LOG2,
    localparam int BY_W     = TY_W + SUB_LOG2,
    localparam int IDX_W    = TX_W + TY_W,
    localparam int MAP_BITS = TILE_COLS * TILE_ROWS,
    localparam int WORDS    = MAP_BITS / WORD_W,
    localparam int WA_W     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [1:0]        frame_kind,
    input  logic              blk_valid,
    input  logic [BX_W-1:0]   blk_x,
    input  logic [BY_W-1:0]   blk_y,
    input  logic              map_we,
    input  logic [WA_W-1:0]   map_waddr,
    input  logic [WORD_W-1:0] map_wdata,
    output logic              coded_valid,
    output logic              coded
);
    logic [IDX_W-1:0] tile_idx;
    logic             tile_bit;

    roi_tile_index #(
        .SUB_LOG2 (SUB_LOG2),
        .TX_W     (TX_W),
        .TY_W     (TY_W)
    ) u_index (
        .blk_x    (blk_x),
        .blk_y    (blk_y),
        .tile_idx (tile_idx)
    );

    roi_map_store #(
        .MAP_BITS (MAP_BITS),
        .WORD_W   (WORD_W),
        .IDX_W    (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (map_we),
        .wr_addr (map_waddr),
        .wr_data (map_wdata),
        .swap    (frame_start),
        .rd_idx  (tile_idx),
        .rd_bit  (tile_bit)
    );

    roi_code_decide u_decide (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_kind  (frame_kind),
        .blk_valid   (blk_valid),
        .map_bit     (tile_bit),
        .coded_valid (coded_valid),
        .coded       (coded)
    );
endmodule

// File: tb/roi_block_gate_bench.sv
`timescale 1ns/1ps
// Bench: exhaustive block sweeps on an 8x4-tile map with 8-bit words.
module roi_block_gate_bench;
    localparam int TC = 8;
    localparam int TR = 4;
    localparam int WW = 8;
    localparam int NB = TC * TR;
    localparam int BXN = TC * 4;
    localparam int BYN = TR * 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic [1:0] frame_kind = 2'd0;
    logic       blk_valid = 1'b0;
    logic [4:0] blk_x = '0;
    logic [3:0] blk_y = '0;
    logic       map_we = 1'b0;
    logic [1:0] map_waddr = '0;
    logic [7:0] map_wdata = '0;
    logic       coded_valid;
    logic       coded;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    logic [1:0]    kind_m = 2'd0;
    logic [NB-1:0] act_m = '0;
    logic [NB-1:0] shd_m = '0;

    always #2 clk = ~clk;

    roi_block_gate #(.TILE_COLS(TC), .TILE_ROWS(TR), .WORD_W(WW)) u_roi_block_gate (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_kind(frame_kind),
        .blk_valid(blk_valid), .blk_x(blk_x), .blk_y(blk_y), .map_we(map_we),
        .map_waddr(map_waddr), .map_wdata(map_wdata),
        .coded_valid(coded_valid), .coded(coded)
    );

    function automatic logic expect_flag(logic [1:0] k, logic [NB-1:0] a, int x, int y);
        if (k != 2'd2) return 1'b1;
        return a[(y / 4) * TC + (x / 4)];
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_word(int a, logic [7:0] d);
        @(negedge clk);
        map_we = 1'b1; map_waddr = a[1:0]; map_wdata = d;
        @(posedge clk); #1;
        map_we = 1'b0;
        shd_m[a*WW +: WW] = d;
    endtask

    task automatic new_frame(logic [1:0] k);
        @(negedge clk);
        frame_start = 1'b1; frame_kind = k;
        @(posedge clk); #1;
        frame_start = 1'b0;
        act_m = shd_m; kind_m = k;
    endtask

    task automatic probe(string req, int x, int y);
        @(negedge clk);
        blk_valid = 1'b1; blk_x = x[4:0]; blk_y = y[3:0];
        @(posedge clk); #1;
        blk_valid = 1'b0;
        chk({req, " strobe"}, coded_valid, 1'b1);
        chk(req, coded, expect_flag(kind_m, act_m, x, y));
    endtask

    task automatic sweep(string req);
        for (int y = 0; y < BYN; y++)
            for (int x = 0; x < BXN; x++)
                probe(req, x, y);
    endtask

    task automatic idle_check();
        @(negedge clk);
        blk_valid = 1'b0;
        @(posedge clk); #1;
        chk("R2 idle strobe", coded_valid, 1'b0);
        chk("R3 idle flag", coded, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        if (!ended) begin
            ended = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs low while reset is held and in the cycle after release.
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset strobe", coded_valid, 1'b0);
        chk("R1 reset flag", coded, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 post-reset strobe", coded_valid, 1'b0);
        chk("R1 post-reset flag", coded, 1'b0);

        // R1, R6: the kind is intra after reset, so every block is coded.
        sweep("R1 R6 intra after reset");
        // R1, R8: the map is cleared by reset, so a mapped frame codes nothing.
        new_frame(2'd2);
        sweep("R1 R8 cleared map");

        // R5, R10: writes made during a frame leave the current decisions alone.
        wr_word(0, 8'hA5);
        wr_word(1, 8'h3C);
        wr_word(2, 8'h01);
        wr_word(3, 8'h80);
        sweep("R10 mid-frame writes held");

        // R4, R5, R8: the new map decides blocks in the next mapped frame.
        new_frame(2'd2);
        sweep("R4 R5 R8 mapped frame");
        new_frame(2'd1);
        sweep("R7 full inter");
        new_frame(2'd3);
        sweep("R9 reserved kind");
        new_frame(2'd0);
        sweep("R6 intra with map");

        idle_check();
        probe("R2 single", 5, 9);
        idle_check();

        // R11, R10: a start pulse, a write and a block all in one cycle.
        @(negedge clk);
        frame_start = 1'b1; frame_kind = 2'd2;
        map_we = 1'b1; map_waddr = 2'd1; map_wdata = 8'hFF;
        blk_valid = 1'b1; blk_x = 5'd0; blk_y = 5'd4;
        @(posedge clk); #1;
        frame_start = 1'b0; map_we = 1'b0; blk_valid = 1'b0;
        chk("R11 same-cycle strobe", coded_valid, 1'b1);
        chk("R11 same-cycle block uses old kind", coded, expect_flag(kind_m, act_m, 0, 4));
        act_m = shd_m; kind_m = 2'd2;
        shd_m[1*WW +: WW] = 8'hFF;
        sweep("R10 R11 same-cycle write deferred");
        new_frame(2'd2);
        sweep("R10 write visible next frame");

        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule